// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for a four-beat burst. On a load cycle it captures a full external address. The two least significant bits of that address become the start value of the burst, and the remaining upper bits are held in a register. On each advance cycle it steps to the next beat address. The low bits follow either a wrapping-increment order or an XOR-interleaved order. A static strap input chooses the order. A clock enable freezes all state.

The address output is built from registered state, so it is valid right after the edge that loaded or advanced it. The strap input is applied directly to the output path. It is intended to be tied to a fixed level, and the bench changes it only between bursts. A memory array sits downstream of this block. It consumes the address, but chip select, data paths and array access stay outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low and after its release with no further cycles, addr_o is all zeros.
- R2: On a rising edge with cke_i=1 and adv_i=0 (load), addr_o takes the value of addr_i from that edge.
- R3: With order_i=0 (linear), the k-th advance after a load gives addr_o[1:0] = (start + k) mod 4, where start is addr_i[1:0] at the load.
- R4: With order_i=1 (interleaved), the k-th advance after a load gives addr_o[1:0] = start XOR (k mod 4).
- R5: On a rising edge with cke_i=0, addr_o keeps its value, whatever adv_i and addr_i are.
- R6: Advances never change addr_o[ADDR_W-1:2]. These bits stay equal to the loaded address.
- R7: After four advances, addr_o returns to the loaded address.
- R8: addr_i has no effect on an edge with adv_i=1.
- R9: A load in the middle of a burst restarts the sequence from the new address, with the beat count back at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable; 0 freezes all state |
| adv_i | input | 1 | 1 = advance the burst, 0 = load addr_i |
| order_i | input | 1 | Static strap: 0 = linear, 1 = interleaved |
| addr_i | input | ADDR_W | External address, captured on load |
| addr_o | output | ADDR_W | Current burst beat address |

## Verification
Every load, advance or stall acts on addr_o within the same rising edge. There is no extra pipeline stage, so each result is due one edge after its inputs are presented. The bench drives inputs on the falling edge. It then waits for the next rising edge and samples one nanosecond later, comparing against a model that is updated for that same edge. A change of order_i acts on addr_o at once with no edge involved, so the bench applies it one cycle before the load that uses it.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/burst_load_reg.sv
module burst_load_reg #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_o <= '0;
    else if (load_i) base_o <= addr_i;
  end

  assert_base_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> base_o == $past(addr_i));
  assert_base_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(base_o));
endmodule

// File: rtl/burst_seq_cnt.sv
module burst_seq_cnt #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (load_i)  cnt_o <= '0;
    else if (step_i)  cnt_o <= cnt_o + 1'b1;
  end

  assert_cnt_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == '0);
  assert_cnt_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && cnt_o == '1) |=> cnt_o == '0);
  assert_cnt_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(cnt_o));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  order_e           order_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] beat_o
);
  logic [CNT_W-1:0] lin_beat;
  logic [CNT_W-1:0] xor_beat;

  assign lin_beat = start_i + cnt_i;

  for (genvar b = 0; b < CNT_W; b++) begin : g_xor
    assign xor_beat[b] = start_i[b] ^ cnt_i[b];
  end

  always_comb begin
    beat_o = (order_i == ORD_XOR) ? xor_beat : lin_beat;
  end

  always_comb begin
    if (cnt_i == '0) assert_start_beat_R2: assert (beat_o == start_i);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic              step;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] cnt;
  logic [BEAT_W-1:0] beat;
  order_e            order;

  assign load  = cke_i && !adv_i;
  assign step  = cke_i && adv_i;
  assign order = order_e'(order_i);

  burst_load_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(load), .addr_i(addr_i), .base_o(base)
  );

  burst_seq_cnt #(.CNT_W(BEAT_W)) u_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step), .cnt_o(cnt)
  );

  burst_order_map #(.CNT_W(BEAT_W)) u_map (
    .order_i(order), .start_i(base[BEAT_W-1:0]), .cnt_i(cnt), .beat_o(beat)
  );

  assign addr_o = {base[ADDR_W-1:BEAT_W], beat};

  assert_load_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> addr_o == $past(addr_i));
  assert_upper_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));
  assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_i && $stable(order_i)) |=> $stable(addr_o));
  assert_step_moves_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && $stable(order_i)) |=> addr_o != $past(addr_o));

  initial begin
    if (HI_W < 1) $error("ADDR_W too small");
  end
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int unsigned AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke = 1'b0;
  logic          adv = 1'b0;
  logic          ord = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] dout;

  int unsigned errors = 0;
  int unsigned checks = 0;

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_k = '0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .adv_i(adv),
    .order_i(ord), .addr_i(addr), .addr_o(dout)
  );

  function automatic logic [AW-1:0] model_addr(logic [AW-1:0] b, logic [1:0] k, logic o);
    logic [1:0] lo;
    lo = o ? (b[1:0] ^ k) : (b[1:0] + k);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic c, logic a, logic [AW-1:0] ad, string tag);
    @(negedge clk);
    cke = c; adv = a; addr = ad;
    @(posedge clk);
    if (c) begin
      if (!a) begin m_base = ad; m_k = 2'd0; end
      else m_k = m_k + 2'd1;
    end
    #1;
    check(tag, dout, model_addr(m_base, m_k, ord));
  endtask

  task automatic set_order(logic o);
    @(negedge clk);
    ord = o; cke = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] a0;
    void'($urandom(32'h5eed_1234));
    #5;
    check("R1 in reset", dout, '0);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1 after release", dout, '0);

    for (int o = 0; o < 2; o++) begin
      set_order(o[0]);
      for (int s = 0; s < 4; s++) begin
        a0 = {$urandom()} % (1 << AW);
        a0[1:0] = s[1:0];
        cyc(1'b1, 1'b0, a0, "R2 load");
        for (int k = 1; k <= 4; k++)
          cyc(1'b1, 1'b1, ~a0, o ? "R4 xor step R8" : "R3 linear step R8");
        check("R7 wrap", dout, a0);
        check("R6 upper", {dout[AW-1:2], 2'b00}, {a0[AW-1:2], 2'b00});
      end
    end

    // directed orders from start 1
    set_order(1'b0);
    cyc(1'b1, 1'b0, 20'h00AB1, "R2 load");
    cyc(1'b1, 1'b1, '0, "R3 lin beat1");
    check("R3 lin beat1 value", dout, 20'h00AB2);
    set_order(1'b1);
    cyc(1'b1, 1'b0, 20'h00AB1, "R2 load");
    cyc(1'b1, 1'b1, '0, "R4 xor beat1");
    check("R4 xor beat1 value", dout, 20'h00AB0);
    cyc(1'b1, 1'b1, '0, "R4 xor beat2");
    check("R4 xor beat2 value", dout, 20'h00AB3);

    // stalls mid-burst
    for (int o = 0; o < 2; o++) begin
      set_order(o[0]);
      cyc(1'b1, 1'b0, 20'h3C5D6, "R2 load");
      cyc(1'b1, 1'b1, '0, "R3 R4 step");
      a0 = dout;
      cyc(1'b0, 1'b0, 20'hFFFFF, "R5 stall load");
      check("R5 stall hold", dout, a0);
      cyc(1'b0, 1'b1, 20'h12345, "R5 stall adv");
      check("R5 stall hold2", dout, a0);
      cyc(1'b1, 1'b1, '0, "R3 R4 resume");
      cyc(1'b1, 1'b0, 20'h0A0A3, "R9 restart");
      check("R9 restart value", dout, 20'h0A0A3);
      cyc(1'b1, 1'b1, '0, "R9 first beat");
    end

    // constrained random, order fixed per segment
    for (int seg = 0; seg < 8; seg++) begin
      set_order(seg[0]);
      cyc(1'b1, 1'b0, AW'($urandom()), "R2 seg load");
      for (int i = 0; i < 200; i++) begin
        logic [3:0] r;
        r = 4'($urandom());
        cyc(r[3:1] != 3'd0, r[2:0] != 3'd0, AW'($urandom()), "R3 R4 R5 R8 R9 random");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule